// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state before any ordinary memory traffic is let through. After a synchronous reset it holds the command output at NOP for a power-up delay. It then steps through a fixed list of device commands. Each command is held for a fixed number of clock cycles. The whole procedure, delay included, is run a set number of times (two by default). Only then does the block raise its done flag and release the refresh inhibit.

The block also produces the 8-bit mode-register data that goes with the mode-register-set command. It takes four static configuration inputs: a CAS latency code, a clock speed class flag, a data bus width flag and an optional preloaded value. The SDRAM pins, the refresh timer and the read/write datapath are outside this block. They consume `cmd_o`, `mode_data_o`, `refresh_inhibit_o` and `done_o`.

Top module: `sdram_init_seq`

## Requirements
- R1: Command codes on `cmd_o` are 0 = NOP, 1 = mode register set, 2 = auto refresh, 3 = precharge all. Each pass issues 20 commands in this order: precharge all, NOP, eight repetitions of (auto refresh, NOP), mode register set, NOP.
- R2: Every command in the list is driven for exactly `HOLD_CYCLES` (default 5) consecutive cycles before the next one appears.
- R3: After reset, `cmd_o` stays NOP for `CLK_MHZ*WAIT_US` cycles before the first precharge, counted from the first clock edge with reset low (`WAIT_US` defaults to 200).
- R4: The wait and the command list together form one pass. `PASSES` (default 2) passes run back to back. Each later pass begins with a full wait of `CLK_MHZ*WAIT_US` NOP cycles.
- R5: `refresh_inhibit_o` is 1 from reset until the final pass completes. It falls only when `done_o` rises.
- R6: `done_o` rises in the cycle after the last NOP of the final pass. It stays 1, with `cmd_o` at NOP, until the next reset.
- R7: With no preload, `mode_data_o` is 0x40 for CAS 2 on a 32-bit bus (`wide_bus`=1) and 0x60 for CAS 3 on a 32-bit bus. For a 16-bit bus (`wide_bus`=0) it is those values shifted right by one: 0x20 and 0x30.
- R8: CAS selection: with `fast_clk`=1 (100 MHz class), `cas_code`=0 selects CAS 2 and any other code selects CAS 3. With `fast_clk`=0 (50 MHz class), `cas_code`=1 selects CAS 2 and any other code selects CAS 3.
- R9: A nonzero `mode_preload` appears on `mode_data_o` unchanged, whatever the other configuration inputs are.
- R10: `rst` high (sampled synchronously) forces `cmd_o`=NOP, `done_o`=0 and `refresh_inhibit_o`=1. Releasing it restarts from the beginning of the first pass's wait, with the pass count cleared, even if the reset came in the middle of a later pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_code | input | 2 | CAS latency code, interpreted according to `fast_clk` |
| fast_clk | input | 1 | 1 = 100 MHz speed class, 0 = 50 MHz |
| wide_bus | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| mode_preload | input | 8 | Nonzero value overrides the computed mode data |
| cmd_o | output | 2 | SDRAM command code |
| mode_data_o | output | 8 | Mode-register data |
| refresh_inhibit_o | output | 1 | Holds off periodic refresh during initialization |
| done_o | output | 1 | Initialization complete |

## Verification
A wrong wait or hold count inside the block shows on `cmd_o` as a command boundary moved by a cycle. This appears at the first precharge, within one wait period of reset. A corrupted list index shows as a wrong command code at the first changed slot. A pass counter that is off shows as `done_o` rising one full pass early or late. A pass counter that reset fails to clear shows in the very first pass after a mid-sequence reset. Mode data has no state, so a wrong decode appears on `mode_data_o` as soon as the configuration inputs settle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_MRS  = 2'd1,
        CMD_REF  = 2'd2,
        CMD_PALL = 2'd3
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] cas_code;
        logic       fast_clk;
        logic       wide_bus;
        logic [7:0] preload;
    } init_cfg_t;

    // Command list: precharge, nop, n_ref x (refresh, nop), mode set, nop
    function automatic sdram_cmd_e cmd_at(input int unsigned idx, input int unsigned n_ref);
        sdram_cmd_e c;
        if (idx == 0)
            c = CMD_PALL;
        else if (idx == 2 * n_ref + 2)
            c = CMD_MRS;
        else if (idx >= 2 && idx < 2 * n_ref + 2 && idx[0] == 1'b0)
            c = CMD_REF;
        else
            c = CMD_NOP;
        return c;
    endfunction

    function automatic logic [7:0] mode_value(input init_cfg_t cfg);
        logic       cas_two;
        logic [7:0] base;
        cas_two = cfg.fast_clk ? (cfg.cas_code == 2'd0) : (cfg.cas_code == 2'd1);
        base    = cas_two ? 8'h40 : 8'h60;
        if (cfg.preload != 8'h00)
            return cfg.preload;
        return cfg.wide_bus ? base : (base >> 1);
    endfunction

endpackage

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc
    import sdram_init_pkg::*;
(
    input  init_cfg_t  cfg,
    output logic [7:0] mode_o
);
    always_comb mode_o = mode_value(cfg);
endmodule

// File: rtl/sdram_step_counter.sv
module sdram_step_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || restart)
            count <= '0;
        else
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sdram_cmd_list.sv
module sdram_cmd_list
    import sdram_init_pkg::*;
#(
    parameter int unsigned N_REF = 8,
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output sdram_cmd_e       cmd
);
    always_comb cmd = cmd_at(int'(idx), N_REF);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned WAIT_US     = 200,
    parameter int unsigned HOLD_CYCLES = 5,
    parameter int unsigned N_REF       = 8,
    parameter int unsigned PASSES      = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cas_code,
    input  logic       fast_clk,
    input  logic       wide_bus,
    input  logic [7:0] mode_preload,
    output logic [1:0] cmd_o,
    output logic [7:0] mode_data_o,
    output logic       refresh_inhibit_o,
    output logic       done_o
);
    localparam int unsigned WAIT_CYCLES = CLK_MHZ * WAIT_US;
    localparam int unsigned N_CMDS      = 2 * N_REF + 4;
    localparam int unsigned MAX_COUNT   = (WAIT_CYCLES > HOLD_CYCLES) ? WAIT_CYCLES : HOLD_CYCLES;
    localparam int unsigned CNT_W       = $clog2(MAX_COUNT + 1);
    localparam int unsigned IDX_W       = $clog2(N_CMDS);
    localparam int unsigned PASS_W      = $clog2(PASSES + 1);
    localparam logic [CNT_W-1:0]  WAIT_LAST = CNT_W'(WAIT_CYCLES - 1);
    localparam logic [CNT_W-1:0]  HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(N_CMDS - 1);
    localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PASS_W-1:0] pass_q;
    logic [CNT_W-1:0]  cnt;
    logic              at_limit;
    sdram_cmd_e        list_cmd;
    init_cfg_t         cfg;

    assign cfg = '{cas_code: cas_code, fast_clk: fast_clk,
                   wide_bus: wide_bus, preload: mode_preload};

    sdram_mode_calc u_mode (
        .cfg    (cfg),
        .mode_o (mode_data_o)
    );

    sdram_cmd_list #(.N_REF(N_REF), .IDX_W(IDX_W)) u_list (
        .idx (idx_q),
        .cmd (list_cmd)
    );

    always_comb begin
        case (state_q)
            ST_WAIT:  at_limit = (cnt == WAIT_LAST);
            ST_ISSUE: at_limit = (cnt == HOLD_LAST);
            default:  at_limit = 1'b1;
        endcase
    end

    sdram_step_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (at_limit),
        .count   (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
            pass_q  <= '0;
        end else begin
            case (state_q)
                ST_WAIT: if (at_limit) begin
                    state_q <= ST_ISSUE;
                    idx_q   <= '0;
                end
                ST_ISSUE: if (at_limit) begin
                    if (idx_q == IDX_LAST) begin
                        idx_q <= '0;
                        if (pass_q == PASS_LAST) begin
                            state_q <= ST_DONE;
                        end else begin
                            pass_q  <= pass_q + 1'b1;
                            state_q <= ST_WAIT;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    assign cmd_o             = (state_q == ST_ISSUE) ? list_cmd : CMD_NOP;
    assign done_o            = (state_q == ST_DONE);
    assign refresh_inhibit_o = (state_q != ST_DONE);

    // R6: completion is sticky
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    // R5: refresh released only together with done
    a_r5_release_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(refresh_inhibit_o) |-> done_o);

    // R2: a command change inside the list happens only after a full hold
    a_r2_hold_full: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE && $past(state_q) == ST_ISSUE && cmd_o != $past(cmd_o))
            |-> $past(cnt) == HOLD_LAST);

    // R1: each list starts with precharge all
    a_r1_first_precharge: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE && $past(state_q) == ST_WAIT) |-> cmd_o == CMD_PALL);

    // R4: done only after the final pass
    a_r4_done_after_last_pass: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(pass_q) == PASS_LAST && $past(state_q) == ST_ISSUE));
endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;
    localparam int unsigned CLK_MHZ = 100;
    localparam int unsigned WAIT_US = 1;
    localparam int unsigned W       = CLK_MHZ * WAIT_US;
    localparam int unsigned HOLD    = 5;

    typedef struct {
        logic [1:0] cmd;
        logic       done;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cas_code = 2'd0;
    logic       fast_clk = 1'b1;
    logic       wide_bus = 1'b1;
    logic [7:0] mode_preload = 8'h00;
    logic [1:0] cmd_o;
    logic [7:0] mode_data_o;
    logic       refresh_inhibit_o;
    logic       done_o;

    int total = 0;
    int bad   = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    exp_item_t q[$];

    always #5 clk = ~clk;

    sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst(rst), .cas_code(cas_code), .fast_clk(fast_clk),
        .wide_bus(wide_bus), .mode_preload(mode_preload), .cmd_o(cmd_o),
        .mode_data_o(mode_data_o), .refresh_inhibit_o(refresh_inhibit_o), .done_o(done_o)
    );

    task automatic push_n(input logic [1:0] c, input logic d, input int n, input string tag);
        for (int i = 0; i < n; i++) q.push_back('{cmd: c, done: d, tag: tag});
    endtask

    // One pass: wait NOPs then the 20-command list
    task automatic push_pass(input int wait_len, input string wait_tag);
        push_n(2'd0, 1'b0, wait_len, wait_tag);
        push_n(2'd3, 1'b0, HOLD, "R1/R2 precharge");
        push_n(2'd0, 1'b0, HOLD, "R1/R2 nop");
        for (int k = 0; k < 8; k++) begin
            push_n(2'd2, 1'b0, HOLD, "R1/R2 refresh");
            push_n(2'd0, 1'b0, HOLD, "R1/R2 nop");
        end
        push_n(2'd1, 1'b0, HOLD, "R1/R2 mode set");
        push_n(2'd0, 1'b0, HOLD, "R1/R2 nop");
    endtask

    task automatic push_run(input string first_tag);
        push_pass(W - 1, first_tag);
        push_pass(W, "R4 second wait");
        push_n(2'd0, 1'b1, 12, "R6 done hold");
    endtask

    // Monitor: pops one expected item per cycle
    always @(posedge clk) begin
        #3;
        if (mon_en && q.size() > 0) begin
            exp_item_t e;
            e = q.pop_front();
            total++;
            if (cmd_o !== e.cmd || done_o !== e.done || refresh_inhibit_o !== !e.done) begin
                bad++;
                $display("FAIL %s (R5 inhibit): cmd=%0d done=%0d inh=%0d expected cmd=%0d done=%0d inh=%0d",
                         e.tag, cmd_o, done_o, refresh_inhibit_o, e.cmd, e.done, !e.done);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mode(input logic fast, input logic [1:0] code, input logic wide);
        bit cas2;
        if (fast) cas2 = (code == 2'd0);
        else      cas2 = (code == 2'd1);
        case ({cas2, wide})
            2'b11:   return 8'h40;
            2'b01:   return 8'h60;
            2'b10:   return 8'h20;
            default: return 8'h30;
        endcase
    endfunction

    task automatic drain;
        while (q.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cmd_o == 2'd0 && done_o == 1'b0 && refresh_inhibit_o == 1'b1,
              "R10 reset outputs", {cmd_o, done_o, refresh_inhibit_o}, 4'b0001);
        @(negedge clk);
        rst = 1'b0;
        push_run("R3 first wait");
        mon_en = 1'b1;
        drain();

        // R7/R8 mode data across all configs
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 2; w++) begin
                    fast_clk = f[0]; cas_code = c[1:0]; wide_bus = w[0];
                    #1;
                    check(mode_data_o == exp_mode(f[0], c[1:0], w[0]), "R7/R8 mode data",
                          mode_data_o, exp_mode(f[0], c[1:0], w[0]));
                end
        // R9 preload override
        mode_preload = 8'h5a; fast_clk = 1'b0; cas_code = 2'd1; wide_bus = 1'b0;
        #1 check(mode_data_o == 8'h5a, "R9 preload", mode_data_o, 8'h5a);
        mode_preload = 8'h01; fast_clk = 1'b1; cas_code = 2'd0; wide_bus = 1'b1;
        #1 check(mode_data_o == 8'h01, "R9 preload", mode_data_o, 8'h01);
        mode_preload = 8'h00;
        #1 check(mode_data_o == 8'h40, "R9 zero preload computes", mode_data_o, 8'h40);
        check(done_o == 1'b1, "R6 done still high", done_o, 1);

        // R10 reset in the middle of the second pass
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (W + 100 + 30) @(negedge clk);
        check(done_o == 1'b0 && refresh_inhibit_o == 1'b1, "R10 mid-run not done",
              {done_o, refresh_inhibit_o}, 2'b01);
        rst = 1'b1;
        mon_en = 1'b0;
        q.delete();
        repeat (2) @(negedge clk);
        check(cmd_o == 2'd0 && done_o == 1'b0, "R10 reset during pass", cmd_o, 0);
        rst = 1'b0;
        push_run("R10 restart wait");
        mon_en = 1'b1;
        drain();

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule